// File: doc/BRIEF.md
# Gated Oscillator Trim Calibrator

This block tunes an on-chip RC oscillator against a crystal reference. It holds a measurement window open for a configurable number of reference clock cycles. During that window it counts oscillator pulses in the oscillator's own clock domain. It then brings the count back to the reference domain and compares it with a tolerance band around the nominal pulse count. After each measurement it nudges a saturating trim code by one step. It repeats until the count falls inside the band or the iteration budget runs out.

A run is started by any of three trigger inputs: power-on initialisation, periodic self-check, and a calibrate command issued from idle. Each trigger only counts when its own enable input is high. A completion pulse can be switched on or off. The nominal pulse count of 200 matches a 6.36 MHz oscillator. The window length is picked so that the nominal oscillator produces that count.

Top module: `occ_trim_calibrator`

## Requirements
- R1: During and right after reset, `busy`, `meas_valid` and `cmd_rdy` are 0 and `trim` holds 32.
- R2: `busy` rises on the clock after an edge where at least one pair is high together: `trig_por` with `en_por`, `trig_check` with `en_check`, or `trig_idle` with `en_idle`. A trigger whose enable is low leaves `busy` at 0.
- R3: A trigger that arrives while `busy` is high has no effect. It does not restart the run and it does not add measurements.
- R4: Each measurement window stays open for `gate_len` reference clock cycles. `meas_count` reports the oscillator rising edges seen in that window, within ±3 of the ideal value.
- R5: A count from 196 to 204 inclusive leaves `trim` unchanged and ends the run.
- R6: A count above 204 lowers `trim` by one step, and a larger trim code means a higher oscillator frequency. A count below 196 raises `trim` by one step. `trim` changes only on the cycle where `meas_valid` is high.
- R7: `trim` saturates at 0 and at 63 and never wraps.
- R8: A run performs at most 16 measurements. It ends after the 16th measurement even if the count is still outside the band.
- R9: `meas_valid` is a single-cycle pulse, once per measurement. In that same cycle `meas_count` and the updated `trim` are visible.
- R10: `busy` falls in the cycle of the run's last `meas_valid`. In that same cycle `cmd_rdy` pulses for one cycle, but only if `evt_en` was high. At all other times `cmd_rdy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Crystal reference clock |
| ref_rst_n | input | 1 | Active-low asynchronous reset, reference domain |
| osc_clk | input | 1 | RC oscillator clock being calibrated |
| osc_rst_n | input | 1 | Active-low asynchronous reset, oscillator domain |
| gate_len | input | 8 | Window length in reference clock cycles |
| trig_por | input | 1 | Power-on initialisation trigger |
| trig_check | input | 1 | Periodic self-check or calibrate-and-check trigger |
| trig_idle | input | 1 | Calibrate command from idle trigger |
| en_por | input | 1 | Enable for `trig_por` |
| en_check | input | 1 | Enable for `trig_check` |
| en_idle | input | 1 | Enable for `trig_idle` |
| evt_en | input | 1 | Enables the completion pulse |
| busy | output | 1 | High for the whole run |
| trim | output | 6 | Oscillator trim code |
| meas_valid | output | 1 | Pulse per completed measurement |
| meas_count | output | 12 | Oscillator pulses counted in the last window |
| cmd_rdy | output | 1 | Completion pulse |

## Verification
The hardest states to reach are the two trim rails and the 16-measurement cutoff. From the ports they only appear when the oscillator stays out of band for a whole run. The bench models the oscillator with a frequency that follows the `trim` output plus an adjustable skew. It applies large positive and negative skews across back-to-back runs, which drives the code into 0 and into 63. A shortened window keeps every count below the band, which exercises the iteration cutoff away from the rails.

// File: rtl/occ_pkg.sv
`timescale 1ps/1ps
package occ_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_GATE = 2'd1,
      ST_WAIT = 2'd2
   } occ_state_e;

   localparam int unsigned NUM_SRC = 3;

endpackage

// File: rtl/occ_sync.sv
`timescale 1ps/1ps
module occ_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/occ_trig_qual.sv
`timescale 1ps/1ps
module occ_trig_qual #(
   parameter int NSRC = 3
) (
   input  logic [NSRC-1:0] trig,
   input  logic [NSRC-1:0] en,
   input  logic            busy,
   output logic            start
);

   logic [NSRC-1:0] armed;

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      assign armed[s] = trig[s] & en[s];
   end

   assign start = !busy && (|armed);

endmodule

// File: rtl/occ_gate_timer.sv
`timescale 1ps/1ps
module occ_gate_timer #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] len,
   output logic             gate,
   output logic             done
);

   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   logic [LEN_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate   <= 1'b0;
         done   <= 1'b0;
         remain <= '0;
      end else begin
         done <= 1'b0;
         if (start && !gate) begin
            if (len == '0) begin
               done <= 1'b1;
            end else begin
               gate   <= 1'b1;
               remain <= len;
            end
         end else if (gate) begin
            if (remain == ONE) begin
               gate <= 1'b0;
               done <= 1'b1;
            end
            remain <= remain - ONE;
         end
      end
   end

endmodule

// File: rtl/occ_count_xfer.sv
`timescale 1ps/1ps
module occ_count_xfer #(
   parameter int CNT_W       = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic             ref_clk,
   input  logic             ref_rst_n,
   input  logic             osc_clk,
   input  logic             osc_rst_n,
   input  logic             gate_ref,
   output logic             cnt_valid,
   output logic [CNT_W-1:0] cnt_data
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   // oscillator domain
   logic             gate_s, gate_d;
   logic             ack_s;
   logic             req_t;
   logic [CNT_W-1:0] pulses;
   logic [CNT_W-1:0] hold;
   logic             pending;

   occ_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
      .clk  (osc_clk),
      .rst_n(osc_rst_n),
      .d    (gate_ref),
      .q    (gate_s)
   );

   assign pending = req_t ^ ack_s;

   always_ff @(posedge osc_clk or negedge osc_rst_n) begin
      if (!osc_rst_n) begin
         gate_d <= 1'b0;
         pulses <= '0;
         hold   <= '0;
         req_t  <= 1'b0;
      end else begin
         gate_d <= gate_s;
         if (gate_s && !gate_d) begin
            pulses <= CNT_ONE;
         end else if (gate_s && pulses != CNT_TOP) begin
            pulses <= pulses + CNT_ONE;
         end
         if (!gate_s && gate_d && !pending) begin
            hold  <= pulses;
            req_t <= ~req_t;
         end
      end
   end

   // reference domain
   logic req_s, req_d;
   logic ack_t;

   occ_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk  (ref_clk),
      .rst_n(ref_rst_n),
      .d    (req_t),
      .q    (req_s)
   );

   always_ff @(posedge ref_clk or negedge ref_rst_n) begin
      if (!ref_rst_n) begin
         req_d     <= 1'b0;
         ack_t     <= 1'b0;
         cnt_valid <= 1'b0;
         cnt_data  <= '0;
      end else begin
         req_d     <= req_s;
         ack_t     <= req_s;
         cnt_valid <= 1'b0;
         if (req_s ^ req_d) begin
            cnt_valid <= 1'b1;
            cnt_data  <= hold;
         end
      end
   end

   occ_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk  (osc_clk),
      .rst_n(osc_rst_n),
      .d    (ack_t),
      .q    (ack_s)
   );

endmodule

// File: rtl/occ_trim_ctrl.sv
`timescale 1ps/1ps
module occ_trim_ctrl
   import occ_pkg::*;
#(
   parameter int TRIM_W    = 6,
   parameter int TRIM_INIT = 32,
   parameter int CNT_W     = 12,
   parameter int TARGET    = 200,
   parameter int TOL_PCT   = 2,
   parameter int MAX_ITER  = 16
) (
   input  logic              ref_clk,
   input  logic              ref_rst_n,
   input  logic              start,
   input  logic              gate_done,
   input  logic              cnt_valid,
   input  logic [CNT_W-1:0]  cnt_data,
   input  logic              evt_en,
   output logic              gate_go,
   output logic              busy,
   output logic [TRIM_W-1:0] trim,
   output logic              meas_valid,
   output logic [CNT_W-1:0]  meas_count,
   output logic              cmd_rdy
);

   localparam int TOL    = (TARGET * TOL_PCT) / 100;
   localparam int LO     = TARGET - TOL;
   localparam int HI     = TARGET + TOL;
   localparam int ITER_W = $clog2(MAX_ITER + 1);

   localparam logic [CNT_W-1:0]  LO_C      = CNT_W'(LO);
   localparam logic [CNT_W-1:0]  HI_C      = CNT_W'(HI);
   localparam logic [TRIM_W-1:0] TRIM_TOP  = '1;
   localparam logic [TRIM_W-1:0] TRIM_ONE  = TRIM_W'(1);
   localparam logic [TRIM_W-1:0] TRIM_RST  = TRIM_W'(TRIM_INIT);
   localparam logic [ITER_W-1:0] ITER_LAST = ITER_W'(MAX_ITER - 1);
   localparam logic [ITER_W-1:0] ITER_ONE  = ITER_W'(1);

   occ_state_e        st;
   logic [ITER_W-1:0] iter;
   logic              too_high, too_low, last_pass, finish;
   logic [TRIM_W-1:0] trim_nxt;

   assign too_high  = cnt_data > HI_C;
   assign too_low   = cnt_data < LO_C;
   assign last_pass = iter == ITER_LAST;
   assign finish    = (!too_high && !too_low) || last_pass;

   always_comb begin
      trim_nxt = trim;
      if (too_high && trim != '0) begin
         trim_nxt = trim - TRIM_ONE;
      end else if (too_low && trim != TRIM_TOP) begin
         trim_nxt = trim + TRIM_ONE;
      end
   end

   assign busy    = st != ST_IDLE;
   assign gate_go = (st == ST_IDLE && start) ||
                    (st == ST_WAIT && cnt_valid && !finish);

   always_ff @(posedge ref_clk or negedge ref_rst_n) begin
      if (!ref_rst_n) begin
         st         <= ST_IDLE;
         iter       <= '0;
         trim       <= TRIM_RST;
         meas_valid <= 1'b0;
         meas_count <= '0;
         cmd_rdy    <= 1'b0;
      end else begin
         meas_valid <= 1'b0;
         cmd_rdy    <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  st   <= ST_GATE;
                  iter <= '0;
               end
            end
            ST_GATE: begin
               if (gate_done) st <= ST_WAIT;
            end
            ST_WAIT: begin
               if (cnt_valid) begin
                  meas_valid <= 1'b1;
                  meas_count <= cnt_data;
                  trim       <= trim_nxt;
                  iter       <= iter + ITER_ONE;
                  if (finish) begin
                     st      <= ST_IDLE;
                     cmd_rdy <= evt_en;
                  end else begin
                     st <= ST_GATE;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/occ_trim_calibrator.sv
`timescale 1ps/1ps
module occ_trim_calibrator
   import occ_pkg::*;
#(
   parameter int TRIM_W      = 6,
   parameter int TRIM_INIT   = 32,
   parameter int GATE_W      = 8,
   parameter int CNT_W       = 12,
   parameter int TARGET      = 200,
   parameter int TOL_PCT     = 2,
   parameter int MAX_ITER    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              ref_clk,
   input  logic              ref_rst_n,
   input  logic              osc_clk,
   input  logic              osc_rst_n,
   input  logic [GATE_W-1:0] gate_len,
   input  logic              trig_por,
   input  logic              trig_check,
   input  logic              trig_idle,
   input  logic              en_por,
   input  logic              en_check,
   input  logic              en_idle,
   input  logic              evt_en,
   output logic              busy,
   output logic [TRIM_W-1:0] trim,
   output logic              meas_valid,
   output logic [CNT_W-1:0]  meas_count,
   output logic              cmd_rdy
);

   if (TRIM_W < 2) begin : g_bad_trim_w
      $error("TRIM_W must be at least 2");
   end
   if (TRIM_INIT < 0 || TRIM_INIT >= (1 << TRIM_W)) begin : g_bad_trim_init
      $error("TRIM_INIT outside trim range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (MAX_ITER < 1) begin : g_bad_iter
      $error("MAX_ITER must be positive");
   end
   if (TARGET + (TARGET * TOL_PCT) / 100 >= (1 << CNT_W) - 1) begin : g_bad_cnt_w
      $error("CNT_W too narrow for TARGET");
   end

   logic [NUM_SRC-1:0] trig_v, en_v;
   logic               start, gate_go, gate, gate_done;
   logic               cnt_valid;
   logic [CNT_W-1:0]   cnt_data;

   assign trig_v = {trig_idle, trig_check, trig_por};
   assign en_v   = {en_idle, en_check, en_por};

   occ_trig_qual #(.NSRC(NUM_SRC)) u_qual (
      .trig (trig_v),
      .en   (en_v),
      .busy (busy),
      .start(start)
   );

   occ_gate_timer #(.LEN_W(GATE_W)) u_gate (
      .clk  (ref_clk),
      .rst_n(ref_rst_n),
      .start(gate_go),
      .len  (gate_len),
      .gate (gate),
      .done (gate_done)
   );

   occ_count_xfer #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_xfer (
      .ref_clk  (ref_clk),
      .ref_rst_n(ref_rst_n),
      .osc_clk  (osc_clk),
      .osc_rst_n(osc_rst_n),
      .gate_ref (gate),
      .cnt_valid(cnt_valid),
      .cnt_data (cnt_data)
   );

   occ_trim_ctrl #(
      .TRIM_W   (TRIM_W),
      .TRIM_INIT(TRIM_INIT),
      .CNT_W    (CNT_W),
      .TARGET   (TARGET),
      .TOL_PCT  (TOL_PCT),
      .MAX_ITER (MAX_ITER)
   ) u_ctrl (
      .ref_clk   (ref_clk),
      .ref_rst_n (ref_rst_n),
      .start     (start),
      .gate_done (gate_done),
      .cnt_valid (cnt_valid),
      .cnt_data  (cnt_data),
      .evt_en    (evt_en),
      .gate_go   (gate_go),
      .busy      (busy),
      .trim      (trim),
      .meas_valid(meas_valid),
      .meas_count(meas_count),
      .cmd_rdy   (cmd_rdy)
   );

endmodule

// File: rtl/occ_trim_calibrator_chk.sv
`timescale 1ps/1ps
module occ_trim_calibrator_chk #(
   parameter int TRIM_W   = 6,
   parameter int CNT_W    = 12,
   parameter int TARGET   = 200,
   parameter int TOL_PCT  = 2,
   parameter int MAX_ITER = 16
) (
   input logic              ref_clk,
   input logic              ref_rst_n,
   input logic              trig_por,
   input logic              trig_check,
   input logic              trig_idle,
   input logic              en_por,
   input logic              en_check,
   input logic              en_idle,
   input logic              evt_en,
   input logic              busy,
   input logic [TRIM_W-1:0] trim,
   input logic              meas_valid,
   input logic [CNT_W-1:0]  meas_count,
   input logic              cmd_rdy
);

   localparam int TOL = (TARGET * TOL_PCT) / 100;
   localparam int LO  = TARGET - TOL;
   localparam int HI  = TARGET + TOL;
   localparam int TOP = (1 << TRIM_W) - 1;

   int meas_in_run;

   always_ff @(posedge ref_clk or negedge ref_rst_n) begin
      if (!ref_rst_n)      meas_in_run <= 0;
      else if (!busy)      meas_in_run <= 0;
      else if (meas_valid) meas_in_run <= meas_in_run + 1;
   end

   a_r2_start_needs_enable: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      $rose(busy) |-> $past((trig_por & en_por) | (trig_check & en_check) | (trig_idle & en_idle)));

   a_r5_window_keeps_trim: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      (meas_valid && int'(meas_count) >= LO && int'(meas_count) <= HI) |-> $stable(trim));

   a_r6_trim_moves_only_on_meas: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      !meas_valid |-> $stable(trim));

   a_r6_single_step: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      meas_valid |-> (int'(trim) == int'($past(trim)) ||
                      int'(trim) == int'($past(trim)) + 1 ||
                      int'(trim) + 1 == int'($past(trim))));

   a_r7_no_wrap: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      meas_valid |-> !((int'($past(trim)) == TOP && int'(trim) == 0) ||
                       (int'($past(trim)) == 0 && int'(trim) == TOP)));

   a_r8_iteration_limit: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      meas_valid |-> meas_in_run < MAX_ITER);

   a_r9_meas_single_cycle: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      meas_valid |=> !meas_valid);

   a_r10_busy_ends_on_meas: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      $fell(busy) |-> meas_valid);

   a_r10_cmd_rdy_at_end: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      cmd_rdy |-> ($fell(busy) && $past(evt_en)));

endmodule

bind occ_trim_calibrator occ_trim_calibrator_chk #(
   .TRIM_W  (TRIM_W),
   .CNT_W   (CNT_W),
   .TARGET  (TARGET),
   .TOL_PCT (TOL_PCT),
   .MAX_ITER(MAX_ITER)
) u_chk (
   .ref_clk   (ref_clk),
   .ref_rst_n (ref_rst_n),
   .trig_por  (trig_por),
   .trig_check(trig_check),
   .trig_idle (trig_idle),
   .en_por    (en_por),
   .en_check  (en_check),
   .en_idle   (en_idle),
   .evt_en    (evt_en),
   .busy      (busy),
   .trim      (trim),
   .meas_valid(meas_valid),
   .meas_count(meas_count),
   .cmd_rdy   (cmd_rdy)
);

// File: tb/occ_trim_calibrator_bench.sv
`timescale 1ps/1ps
module occ_trim_calibrator_bench;

   localparam int REF_PERIOD = 10000;
   localparam int TRIM_INIT  = 32;
   localparam int WIN_LO     = 196;
   localparam int WIN_HI     = 204;
   localparam int ITER_MAX   = 16;

   logic        ref_clk = 1'b0;
   logic        osc_clk = 1'b0;
   logic        ref_rst_n = 1'b0;
   logic [7:0]  gate_len = 8'd200;
   logic        trig_por = 1'b0, trig_check = 1'b0, trig_idle = 1'b0;
   logic        en_por = 1'b0, en_check = 1'b0, en_idle = 1'b0;
   logic        evt_en = 1'b0;
   logic        busy, meas_valid, cmd_rdy;
   logic [5:0]  trim;
   logic [11:0] meas_count;

   int n_checks = 0;
   int n_errors = 0;
   int skew = 0;
   bit finished = 0;

   // model state
   bit m_busy = 0;
   int m_trim = TRIM_INIT;
   int m_iter = 0;
   bit prev_mv = 0;
   int n_runs = 0;
   int n_rdy = 0;
   int last_iters = 0;
   int last_cnt = 0;

   occ_trim_calibrator u_occ_trim_calibrator (
      .ref_clk   (ref_clk),
      .ref_rst_n (ref_rst_n),
      .osc_clk   (osc_clk),
      .osc_rst_n (ref_rst_n),
      .gate_len  (gate_len),
      .trig_por  (trig_por),
      .trig_check(trig_check),
      .trig_idle (trig_idle),
      .en_por    (en_por),
      .en_check  (en_check),
      .en_idle   (en_idle),
      .evt_en    (evt_en),
      .busy      (busy),
      .trim      (trim),
      .meas_valid(meas_valid),
      .meas_count(meas_count),
      .cmd_rdy   (cmd_rdy)
   );

   always #(REF_PERIOD / 2) ref_clk = ~ref_clk;

   // oscillator model: frequency proportional to (100 + trim - 32 + skew)
   function automatic int osc_half(input int t);
      int den;
      den = 100 + t - TRIM_INIT + skew;
      if (den < 5) den = 5;
      return 500000 / den;
   endfunction

   always begin : osc_gen
      int h;
      if ($isunknown(trim)) h = 5000;
      else                  h = osc_half(int'(trim));
      #(h);
      osc_clk = ~osc_clk;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // per-clock reference model
   always @(posedge ref_clk) begin : model
      bit q;
      bit ev;
      int est;
      int cnt;
      bit fin;
      q  = (trig_por & en_por) | (trig_check & en_check) | (trig_idle & en_idle);
      ev = evt_en;
      #1;
      if (!ref_rst_n) begin
         m_busy  = 0;
         m_trim  = TRIM_INIT;
         m_iter  = 0;
         prev_mv = 0;
      end else begin
         if (q && !m_busy) begin
            m_busy = 1;
            m_iter = 0;
            n_runs++;
         end
         if (meas_valid) begin
            cnt = int'(meas_count);
            chk(!prev_mv, "R9 meas_valid longer than one cycle", 1, 0);
            chk(m_busy, "R9 meas_valid outside a run", 0, 1);
            est = int'(gate_len) * REF_PERIOD / (2 * osc_half(m_trim));
            chk(cnt >= est - 3 && cnt <= est + 3, "R4 meas_count", cnt, est);
            if (cnt > WIN_HI)      m_trim = (m_trim == 0)  ? 0  : m_trim - 1;
            else if (cnt < WIN_LO) m_trim = (m_trim == 63) ? 63 : m_trim + 1;
            m_iter++;
            fin = (cnt >= WIN_LO && cnt <= WIN_HI) || (m_iter == ITER_MAX);
            if (fin) begin
               m_busy     = 0;
               last_iters = m_iter;
               last_cnt   = cnt;
               chk(cmd_rdy == ev, "R10 cmd_rdy at run end", int'(cmd_rdy), int'(ev));
               if (cmd_rdy) n_rdy++;
            end else begin
               chk(!cmd_rdy, "R10 cmd_rdy mid run", int'(cmd_rdy), 0);
            end
         end else begin
            chk(!cmd_rdy, "R10 cmd_rdy without measurement", int'(cmd_rdy), 0);
         end
         chk(busy == m_busy, "R2 R3 busy", int'(busy), int'(m_busy));
         chk(int'(trim) == m_trim, "R6 R7 trim", int'(trim), m_trim);
         prev_mv = meas_valid;
      end
   end

   task automatic pulse(input int which);
      @(negedge ref_clk);
      case (which)
         0: trig_por   = 1'b1;
         1: trig_check = 1'b1;
         default: trig_idle = 1'b1;
      endcase
      @(negedge ref_clk);
      trig_por   = 1'b0;
      trig_check = 1'b0;
      trig_idle  = 1'b0;
   endtask

   task automatic wait_idle();
      int k;
      k = 0;
      @(negedge ref_clk);
      while (busy && k < 20000) begin
         @(negedge ref_clk);
         k++;
      end
      repeat (3) @(negedge ref_clk);
   endtask

   task automatic do_reset();
      @(negedge ref_clk);
      ref_rst_n = 1'b0;
      repeat (4) @(negedge ref_clk);
      ref_rst_n = 1'b1;
      @(negedge ref_clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   endtask

   initial begin : watchdog
      #(64'(REF_PERIOD) * 150000);
      n_errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin : stimulus
      int r0;
      int rdy0;
      repeat (5) @(negedge ref_clk);
      // R1 state while still in reset
      chk(!busy && !meas_valid && !cmd_rdy, "R1 outputs in reset", int'(busy), 0);
      ref_rst_n = 1'b1;
      @(negedge ref_clk);
      chk(!busy, "R1 busy after reset", int'(busy), 0);
      chk(int'(trim) == TRIM_INIT, "R1 trim after reset", int'(trim), TRIM_INIT);
      chk(!cmd_rdy && !meas_valid, "R1 pulses after reset", int'(cmd_rdy), 0);

      // R2: disabled triggers have no effect
      skew = -5;
      evt_en = 1'b1;
      pulse(0);
      pulse(1);
      pulse(2);
      repeat (10) @(negedge ref_clk);
      chk(!busy, "R2 disabled triggers", int'(busy), 0);
      chk(int'(trim) == TRIM_INIT, "R2 trim untouched by disabled triggers", int'(trim), TRIM_INIT);

      // R2 power-on trigger, R3 trigger during a run, R5/R10 convergence with event
      en_por = 1'b1;
      r0 = n_runs;
      rdy0 = n_rdy;
      pulse(0);
      chk(busy, "R2 por start", int'(busy), 1);
      repeat (300) @(negedge ref_clk);
      pulse(0);
      wait_idle();
      chk(n_runs == r0 + 1, "R3 trigger while busy ignored", n_runs, r0 + 1);
      chk(last_iters < ITER_MAX && last_cnt >= WIN_LO && last_cnt <= WIN_HI,
          "R5 converged count in window", last_cnt, 200);
      chk(n_rdy == rdy0 + 1, "R10 event raised when enabled", n_rdy, rdy0 + 1);

      // check trigger, event masked, oscillator now fast
      en_por = 1'b0;
      en_check = 1'b1;
      evt_en = 1'b0;
      skew = 4;
      rdy0 = n_rdy;
      pulse(1);
      chk(busy, "R2 check start", int'(busy), 1);
      wait_idle();
      chk(n_rdy == rdy0, "R10 event masked", n_rdy, rdy0);
      chk(last_cnt >= WIN_LO && last_cnt <= WIN_HI, "R5 converged downward", last_cnt, 200);

      // idle trigger
      en_check = 1'b0;
      pulse(2);
      repeat (5) @(negedge ref_clk);
      chk(!busy, "R2 idle trigger disabled", int'(busy), 0);
      en_idle = 1'b1;
      evt_en = 1'b1;
      skew = -3;
      pulse(2);
      chk(busy, "R2 idle start", int'(busy), 1);
      wait_idle();
      en_idle = 1'b0;

      // R7/R8 upper rail: oscillator far too slow
      do_reset();
      skew = -60;
      en_por = 1'b1;
      for (int i = 0; i < 3; i++) begin
         pulse(0);
         wait_idle();
         chk(last_iters == ITER_MAX, "R8 run stops after 16 measurements", last_iters, ITER_MAX);
      end
      chk(int'(trim) == 63, "R7 saturate at 63", int'(trim), 63);

      // R7 lower rail: oscillator far too fast
      do_reset();
      skew = 80;
      for (int i = 0; i < 3; i++) begin
         pulse(0);
         wait_idle();
      end
      chk(int'(trim) == 0, "R7 saturate at 0", int'(trim), 0);

      // R4/R6/R8 shorter window keeps every count low
      do_reset();
      skew = 0;
      gate_len = 8'd100;
      pulse(0);
      wait_idle();
      chk(last_iters == ITER_MAX, "R8 cutoff with short window", last_iters, ITER_MAX);
      chk(int'(trim) == TRIM_INIT + ITER_MAX, "R6 one step per measurement", int'(trim), TRIM_INIT + ITER_MAX);

      repeat (5) @(negedge ref_clk);
      finish_run();
   end

endmodule